// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block gathers eight board-level interrupt requests and folds them into a single active-low request line for a processor. Each source is first brought into the local clock domain. A per-source detector then looks for either a level or a transition, in a direction chosen per source. A detected event sets a pending bit. That bit stays set until software writes a one to it, even if the source has gone quiet by then.

Software reaches the configuration through a byte-wide address/data port. The port has a write strobe and a combinational read path. The per-source settings are the trigger type, the active sense and a mask. One control bit gates the shared output on or off. The processor has no vector input, so the block holds a scratch byte that software may use as it likes. The scratch byte has no effect on the hardware.

Top module: `sticky_irq_agg`

## Requirements
- R1: After reset, trigger-type reads 0x00 (all sources level), sense reads 0x00, mask reads 0xFC (sources 0 and 1 unmasked), pending reads 0x00, scratch reads 0x00, control reads 0x00, and irq_n is 1.
- R2: The registers sit at these offsets: trigger-type 0xA0, sense 0xA1, mask 0xA2, pending 0xA3, scratch 0xA6 and control 0xA7. A write with reg_we high updates the addressed register on the clock edge. Trigger-type, sense, mask and scratch read back all eight bits. Control reads back bit 0 only, and its other bits read 0. Reads from any other address return 0x00.
- R3: A change on src_i can set a pending bit no earlier than the third rising clock edge after the change. The bit is set on that third edge.
- R4: For a source whose trigger-type bit is 0 (level), the pending bit is set while the synchronized input equals its sense bit. A sense bit of 1 means active high, and 0 means active low.
- R5: For a source whose trigger-type bit is 1 (edge), the pending bit is set only on a transition into the sense level. A sense bit of 1 means a rising edge, and 0 means a falling edge. An input held at a steady level sets nothing.
- R6: A set pending bit stays set after its source returns to inactive, until software clears it.
- R7: Writing to pending clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. If a level source is still active during the clear, its bit is set again on the same edge, so the bit never reads 0.
- R8: irq_n is 0 exactly when control bit 0 is 1 and at least one pending bit has its mask bit at 0. A mask bit of 1 stops the source from driving irq_n but does not stop its pending bit from being set.
- R9: Writing the scratch register changes neither irq_n nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Raw interrupt sources, asynchronous to clk |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Merged interrupt request, active low |

## Verification
A vector table drives all eight sources at once, with each source set to a different mix of trigger type, sense and mask. The table covers these cases:
- Level-low and level-high sensing on complementary source patterns, which separates the sense polarities.
- Rising and falling edge modes run on the same before/after source values, which shows whether the edge direction is honoured.
- A fully masked case and an enable-off case, which separate status latching from output gating.
- A case where a source is active during the clear and then goes away, which tests stickiness and re-arming together.

Directed steps then check the exact edge on which a bit is set, partial clears, and a level source re-setting during a write-1-to-clear. They also check that a source held steady in edge mode sets nothing.

// File: rtl/sia_pkg.sv
package sia_pkg;

  // register selector produced by the address decoder
  typedef enum logic [2:0] {
    SEL_TRIG,
    SEL_SENSE,
    SEL_MASK,
    SEL_PEND,
    SEL_SCR,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;

  // one source: does the current sample constitute an event?
  function automatic logic src_hit(input logic edge_md, input logic sense,
                                   input logic cur, input logic prv);
    logic on_now;
    logic on_before;
    on_now    = (cur == sense);
    on_before = (prv == sense);
    return edge_md ? (on_now && !on_before) : on_now;
  endfunction

endpackage

// File: rtl/sia_sync.sv
module sia_sync #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);

  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= IDLE;
      cur    <= IDLE;
      prv    <= IDLE;
    end else begin
      stage1 <= raw;
      cur    <= stage1;
      prv    <= cur;
    end
  end

endmodule

// File: rtl/sia_detect.sv
module sia_detect
  import sia_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prv,
  output logic [N-1:0] hit
);

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = src_hit(trig[i], sense[i], cur[i], prv[i]);

    // R5
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && hit[i]) |-> (cur[i] != prv[i]));
  end

endmodule

// File: rtl/sia_regs.sv
module sia_regs
  import sia_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_TRIG  = 8'hA0,
  parameter logic [ADDR_W-1:0] OFF_SENSE = 8'hA1,
  parameter logic [ADDR_W-1:0] OFF_MASK  = 8'hA2,
  parameter logic [ADDR_W-1:0] OFF_PEND  = 8'hA3,
  parameter logic [ADDR_W-1:0] OFF_SCR   = 8'hA6,
  parameter logic [ADDR_W-1:0] OFF_CTRL  = 8'hA7,
  parameter logic [N-1:0] TRIG_RST  = '0,
  parameter logic [N-1:0] SENSE_RST = '0,
  parameter logic [N-1:0] MASK_RST  = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      hit,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      trig,
  output logic [N-1:0]      sense,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      pend,
  output logic              ctrl_en
);

  reg_sel_e     sel;
  logic [N-1:0] scratch;
  logic [N-1:0] clr_v;

  always_comb begin
    if      (addr == OFF_TRIG)  sel = SEL_TRIG;
    else if (addr == OFF_SENSE) sel = SEL_SENSE;
    else if (addr == OFF_MASK)  sel = SEL_MASK;
    else if (addr == OFF_PEND)  sel = SEL_PEND;
    else if (addr == OFF_SCR)   sel = SEL_SCR;
    else if (addr == OFF_CTRL)  sel = SEL_CTRL;
    else                        sel = SEL_NONE;
  end

  assign clr_v = (wr_en && sel == SEL_PEND) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig    <= TRIG_RST;
      sense   <= SENSE_RST;
      mask    <= MASK_RST;
      pend    <= '0;
      scratch <= '0;
      ctrl_en <= 1'b0;
    end else begin
      pend <= (pend & ~clr_v) | hit;
      if (wr_en) begin
        case (sel)
          SEL_TRIG:  trig    <= wdata;
          SEL_SENSE: sense   <= wdata;
          SEL_MASK:  mask    <= wdata;
          SEL_SCR:   scratch <= wdata;
          SEL_CTRL:  ctrl_en <= wdata[0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_TRIG:  rdata = trig;
      SEL_SENSE: rdata = sense;
      SEL_MASK:  rdata = mask;
      SEL_PEND:  rdata = pend;
      SEL_SCR:   rdata = scratch;
      SEL_CTRL:  rdata = {{(N-1){1'b0}}, ctrl_en};
      default:   rdata = '0;
    endcase
  end

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(clr_v)) & ~pend) == '0));

  // R3
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend & ~$past(pend)) & ~$past(hit)) == '0));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_v) |=> ((pend & $past(clr_v) & ~$past(hit)) == '0));

endmodule

// File: rtl/sticky_irq_agg.sv
module sticky_irq_agg #(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N-1:0] MASK_RST  = 8'hFC,
  parameter logic [N-1:0] SENSE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  input  logic              reg_we,
  output logic [N-1:0]      reg_rdata,
  output logic              irq_n
);

  logic [N-1:0] cur, prv, hit;
  logic [N-1:0] trig, sense, mask, pend;
  logic         ctrl_en;
  logic         any_req;

  sia_sync #(.N(N), .IDLE(~SENSE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_i), .cur(cur), .prv(prv)
  );

  sia_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sense(sense),
    .cur(cur), .prv(prv), .hit(hit)
  );

  sia_regs #(.N(N), .ADDR_W(ADDR_W), .SENSE_RST(SENSE_RST), .MASK_RST(MASK_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit), .rdata(reg_rdata), .trig(trig), .sense(sense), .mask(mask),
    .pend(pend), .ctrl_en(ctrl_en)
  );

  assign any_req = |(pend & ~mask);
  assign irq_n   = ~(ctrl_en & any_req);

  // R8
  quiet_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) == '0) |-> irq_n);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> irq_n);

  // R4
  level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~trig & ~(cur ^ sense)) & ~pend) == '0));

endmodule

// File: tb/sticky_irq_agg_test.sv
`timescale 1ns/1ps
module sticky_irq_agg_test;

  localparam logic [7:0] A_TRIG = 8'hA0, A_SENSE = 8'hA1, A_MASK = 8'hA2,
                         A_PEND = 8'hA3, A_SCR = 8'hA6, A_CTRL = 8'hA7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_i = 8'hFF;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sticky_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // trig, sense, mask, ctrl, src before, src after
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h01, 8'hFF, 8'hF0},
    {8'h00, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h05},
    {8'hFF, 8'hFF, 8'h00, 8'h01, 8'h0F, 8'h3C},
    {8'hFF, 8'h00, 8'h00, 8'h01, 8'h0F, 8'h3C},
    {8'h00, 8'h00, 8'hFF, 8'h01, 8'hFF, 8'h00},
    {8'h0F, 8'hF0, 8'h0F, 8'h01, 8'hAA, 8'h55},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h7F},
    {8'hFF, 8'hFF, 8'hFE, 8'h01, 8'h00, 8'h01},
    {8'h00, 8'h00, 8'h00, 8'h01, 8'hFE, 8'hFF}
  };

  // expected pending after: clear while 'before' held, then move to 'after'
  function automatic logic [7:0] model_pend(input logic [7:0] tg, input logic [7:0] sn,
                                            input logic [7:0] b, input logic [7:0] a);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      logic act_b, act_a;
      act_b = ~(b[k] ^ sn[k]);
      act_a = ~(a[k] ^ sn[k]);
      r[k] = tg[k] ? (act_a & ~act_b) : (act_a | act_b);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_TRIG, v);  chk("R1 trig", v, 8'h00);
    rd(A_SENSE, v); chk("R1 sense", v, 8'h00);
    rd(A_MASK, v);  chk("R1 mask", v, 8'hFC);
    rd(A_PEND, v);  chk("R1 pend", v, 8'h00);
    rd(A_SCR, v);   chk("R1 scratch", v, 8'h00);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);

    // R2 readback and decode
    wr(A_TRIG, 8'h5A);  rd(A_TRIG, v);  chk("R2 trig", v, 8'h5A);
    wr(A_SENSE, 8'h3C); rd(A_SENSE, v); chk("R2 sense", v, 8'h3C);
    wr(A_MASK, 8'h81);  rd(A_MASK, v);  chk("R2 mask", v, 8'h81);
    wr(A_CTRL, 8'hFF);  rd(A_CTRL, v);  chk("R2 ctrl", v, 8'h01);
    rd(8'h10, v); chk("R2 unmapped", v, 8'h00);
    rd(8'hA4, v); chk("R2 unmapped", v, 8'h00);

    // table walk: R4 R5 R6 R7 R8
    for (int e = 0; e < NV; e++) begin
      logic [7:0] tg, sn, mk, ct, bf, af, ep;
      {tg, sn, mk, ct, bf, af} = VEC[e];
      wr(A_TRIG, tg); wr(A_SENSE, sn); wr(A_MASK, mk); wr(A_CTRL, ct);
      src_i = bf; settle();
      wr(A_PEND, 8'hFF);
      src_i = af; settle();
      ep = model_pend(tg, sn, bf, af);
      rd(A_PEND, v);
      chk($sformatf("R4/R5 vector %0d pend", e), v, ep);
      chk($sformatf("R8 vector %0d irq_n", e), {7'd0, irq_n},
          {7'd0, ~(ct[0] & (|(ep & ~mk)))});
    end

    // R3 latency: level active-low on bit 2
    wr(A_TRIG, 8'h00); wr(A_SENSE, 8'h00); wr(A_MASK, 8'h00); wr(A_CTRL, 8'h01);
    src_i = 8'hFF; settle(); wr(A_PEND, 8'hFF);
    reg_addr = A_PEND;
    @(negedge clk); src_i = 8'hFB;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R3 not before third edge", reg_rdata, 8'h00);
    @(negedge clk); chk("R3 set on third edge", reg_rdata, 8'h04);
    chk("R3 irq_n", {7'd0, irq_n}, 8'h00);

    // R6 sticky after removal
    src_i = 8'hFF; settle();
    rd(A_PEND, v); chk("R6 sticky", v, 8'h04);

    // R7 partial clear
    src_i = 8'hF9; settle(); src_i = 8'hFF; settle();
    rd(A_PEND, v); chk("R7 two set", v, 8'h06);
    wr(A_PEND, 8'h02); rd(A_PEND, v); chk("R7 partial", v, 8'h04);
    wr(A_PEND, 8'h04); rd(A_PEND, v); chk("R7 all clear", v, 8'h00);
    chk("R8 idle irq_n", {7'd0, irq_n}, 8'h01);

    // R7 still-active level re-sets
    src_i = 8'hFE; settle();
    wr(A_PEND, 8'h01);
    #1 chk("R7 reassert", reg_rdata, 8'h01);

    // R8 masking and enable
    wr(A_MASK, 8'h01); #1 chk("R8 masked irq_n", {7'd0, irq_n}, 8'h01);
    rd(A_PEND, v); chk("R8 masked still pending", v, 8'h01);
    wr(A_MASK, 8'h00); #1 chk("R8 unmasked irq_n", {7'd0, irq_n}, 8'h00);
    wr(A_CTRL, 8'h00); #1 chk("R8 disabled irq_n", {7'd0, irq_n}, 8'h01);
    wr(A_CTRL, 8'h01);

    // R9 scratch has no hardware effect
    src_i = 8'hFF; settle(); wr(A_PEND, 8'hFF);
    wr(A_SCR, 8'hFF);
    #1 chk("R9 irq_n", {7'd0, irq_n}, 8'h01);
    rd(A_PEND, v); chk("R9 pend", v, 8'h00);
    rd(A_SCR, v);  chk("R9 scratch readback", v, 8'hFF);

    // R5 steady level in edge mode sets nothing
    wr(A_TRIG, 8'hFF); wr(A_SENSE, 8'h00);
    src_i = 8'h00; settle();
    rd(A_PEND, v); chk("R5 falling all", v, 8'hFF);
    wr(A_PEND, 8'hFF); settle();
    rd(A_PEND, v); chk("R5 steady none", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule